// File: doc/BRIEF.md
# Bounds-Checked Indexed Element Move

This unit moves 16-bit elements within an 8-element vector under control of a packed vector of 4-bit indexes. In gather mode every destination position fetches the source element its own index names. In scatter mode every source position writes its element to the destination position its index names. Indexes are compared against the active vector length, not against the vector capacity. A fetch through an index at or beyond that length yields zero, and a write aimed at or beyond it is dropped. The comparison results are folded into the predicate mask, so the unit has no undefined behaviour for any index value.

A caller presents the source vector, the index vector, a predicate mask, the previous destination contents and the active length, then raises `start` for one cycle. In the following cycle `done` is high for exactly one cycle and `dstVec` holds the new destination vector. `dstVec` stays unchanged until the next start. Each result element is always computed. A per-element multiplexer then keeps the previous destination value wherever the merged predicate is clear.

Top module: `idxmv_unit`

## Requirements
- R1: While `rstN` is low at a rising clock edge, `dstVec` is cleared to zero and `done` to 0.
- R2: When `start` is high at a rising edge, `done` is 1 for the following cycle only and `dstVec` shows the result in that cycle. Without `start`, `done` is 0 and `dstVec` does not change.
- R3: With `scatterMode` = 0 (gather), destination element i (bits 16i+15..16i) becomes source element k, where k is the 4-bit index field at bits 4i+3..4i. This applies when predicate bit i is 1, i is below the active length and k is below the active length.
- R4: In gather mode, an enabled destination element whose index is at or above the active length is written with zero. This includes index values 8 to 15.
- R5: A destination element whose predicate bit is 0 keeps its previous value in both modes.
- R6: Destination positions at or above the active length keep their previous values whatever their predicate bits are. A length of 0 leaves the whole vector unchanged.
- R7: The active length is `vecLen`, and `vecLen` values 9 to 15 act as 8. The unit uses `vecLen` and not the capacity of 8. Out-of-range gather indexes therefore give zero even when they are below 8.
- R8: With `scatterMode` = 1 (scatter), source element i is written to destination position k (index field i) when predicate bit i is 1, i is below the active length and k is below the active length. Positions that no write reaches keep their previous values.
- R9: In scatter mode, a write whose target index is at or above the active length is dropped, and the destination element there keeps its previous value.
- R10: In scatter mode, when several enabled source positions target the same destination position, the highest source position wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a move, sampled at the rising edge |
| scatterMode | input | 1 | 0 selects gather, 1 selects scatter |
| vecLen | input | 4 | Active vector length; values above 8 act as 8 |
| srcVec | input | 128 | Packed source elements, element 0 in the low bits |
| idxVec | input | 32 | Packed 4-bit indexes, index 0 in the low bits |
| predMask | input | 8 | Per-element predicate, bit i for position i |
| oldVec | input | 128 | Previous destination contents |
| dstVec | output | 128 | Registered new destination contents |
| done | output | 1 | One-cycle pulse when `dstVec` is updated |

## Verification
Gather is tried with an identity index set and with a reversed one at full length. These two patterns show that routing really follows the indexes and is not a fixed pass-through. Further patterns mix in indexes between the active length and 8 and indexes from 9 to 15. Another pattern sets a length above 8. These separate zeroing of out-of-range fetches from keeping the old tail, and show that the comparison uses the length rather than the capacity. Scatter is tried with a permutation, with targets beyond the length, and with every source aimed at one position. Those cases separate dropped writes, untouched positions and the priority rule. Predicate patterns with alternating and empty masks show that the old destination value is kept.

// File: rtl/idxmv_pkg.sv
package idxmv_pkg;

  typedef enum logic {
    MODE_GATHER  = 1'b0,
    MODE_SCATTER = 1'b1
  } moveMode_e;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic      capture;
    moveMode_e mode;
  } moveStrobe_t;

endpackage

// File: rtl/idxmv_ctrl.sv
module idxmv_ctrl
  import idxmv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        scatterMode,
  output moveStrobe_t strobe,
  output logic        done
);

  always_comb begin
    strobe.capture = start;
    strobe.mode    = scatterMode ? MODE_SCATTER : MODE_GATHER;
  end

  // done marks the cycle in which the registered result is first visible
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
    end else begin
      done <= start;
    end
  end

endmodule

// File: rtl/idxmv_bounds.sv
module idxmv_bounds #(
  parameter int NUM_ELEM = 8,
  parameter int IDX_W    = 4,
  parameter int VL_W     = 4
) (
  input  logic [NUM_ELEM*IDX_W-1:0] idxVec,
  input  logic [VL_W-1:0]           vecLen,
  output logic [NUM_ELEM-1:0]       posOk,
  output logic [NUM_ELEM-1:0]       idxOk
);

  localparam int CMP_W = (IDX_W > VL_W) ? IDX_W : VL_W;
  localparam logic [VL_W-1:0] CAP_LEN = VL_W'(NUM_ELEM);

  logic [VL_W-1:0]  effLen;
  logic [CMP_W-1:0] lenWide;

  // Lengths above capacity saturate to capacity
  assign effLen  = (vecLen > CAP_LEN) ? CAP_LEN : vecLen;
  assign lenWide = CMP_W'(effLen);

  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_cmp
    logic [IDX_W-1:0] idxField;
    assign idxField  = idxVec[gi*IDX_W +: IDX_W];
    assign idxOk[gi] = (CMP_W'(idxField) < lenWide);
    assign posOk[gi] = (CMP_W'(gi) < lenWide);
  end

endmodule

// File: rtl/idxmv_datapath.sv
module idxmv_datapath
  import idxmv_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16,
  parameter int IDX_W    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  moveStrobe_t                strobe,
  input  logic [NUM_ELEM*ELEM_W-1:0] srcVec,
  input  logic [NUM_ELEM*IDX_W-1:0]  idxVec,
  input  logic [NUM_ELEM-1:0]        predMask,
  input  logic [NUM_ELEM*ELEM_W-1:0] oldVec,
  input  logic [NUM_ELEM-1:0]        posOk,
  input  logic [NUM_ELEM-1:0]        idxOk,
  output logic [NUM_ELEM*ELEM_W-1:0] dstVec
);

  localparam int VEC_W = NUM_ELEM * ELEM_W;

  logic [ELEM_W-1:0] srcElem  [NUM_ELEM];
  logic [ELEM_W-1:0] oldElem  [NUM_ELEM];
  logic [IDX_W-1:0]  idxElem  [NUM_ELEM];
  logic [ELEM_W-1:0] gathVal  [NUM_ELEM];
  logic [ELEM_W-1:0] scatVal  [NUM_ELEM];
  logic [NUM_ELEM-1:0] gathEn;
  logic [NUM_ELEM-1:0] scatHit;
  logic [NUM_ELEM-1:0] srcLive;
  logic [VEC_W-1:0]  nextVec;

  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_unpack
    assign srcElem[gi] = srcVec[gi*ELEM_W +: ELEM_W];
    assign oldElem[gi] = oldVec[gi*ELEM_W +: ELEM_W];
    assign idxElem[gi] = idxVec[gi*IDX_W +: IDX_W];
  end

  // Gather: fetch by index, then AND with a mask built from the range bit
  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_gather
    logic [ELEM_W-1:0] rawFetch;
    always_comb begin
      rawFetch = '0;
      for (int k = 0; k < NUM_ELEM; k++) begin
        if (idxElem[gi] == IDX_W'(k)) begin
          rawFetch = srcElem[k];
        end
      end
    end
    assign gathVal[gi] = rawFetch & {ELEM_W{idxOk[gi]}};
    // Write target in gather is the position itself
    assign gathEn[gi]  = predMask[gi] & posOk[gi];
  end

  // Scatter: a source is live when predicated, inside length, target in range
  assign srcLive = predMask & posOk & idxOk;

  for (genvar gj = 0; gj < NUM_ELEM; gj++) begin : g_scatter
    always_comb begin
      scatHit[gj] = 1'b0;
      scatVal[gj] = '0;
      // Ascending scan: the last match, the highest source, wins
      for (int i = 0; i < NUM_ELEM; i++) begin
        if (srcLive[i] && (idxElem[i] == IDX_W'(gj))) begin
          scatHit[gj] = 1'b1;
          scatVal[gj] = srcElem[i];
        end
      end
    end
  end

  // Final per-element mux against the previous destination value
  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_merge
    logic              wrEn;
    logic [ELEM_W-1:0] newVal;
    always_comb begin
      if (strobe.mode == MODE_SCATTER) begin
        wrEn   = scatHit[gi];
        newVal = scatVal[gi];
      end else begin
        wrEn   = gathEn[gi];
        newVal = gathVal[gi];
      end
    end
    assign nextVec[gi*ELEM_W +: ELEM_W] = wrEn ? newVal : oldElem[gi];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstVec <= '0;
    end else if (strobe.capture) begin
      dstVec <= nextVec;
    end
  end

endmodule

// File: rtl/idxmv_unit.sv
module idxmv_unit
  import idxmv_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16,
  parameter int IDX_W    = 4,
  parameter int VL_W     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       scatterMode,
  input  logic [VL_W-1:0]            vecLen,
  input  logic [NUM_ELEM*ELEM_W-1:0] srcVec,
  input  logic [NUM_ELEM*IDX_W-1:0]  idxVec,
  input  logic [NUM_ELEM-1:0]        predMask,
  input  logic [NUM_ELEM*ELEM_W-1:0] oldVec,
  output logic [NUM_ELEM*ELEM_W-1:0] dstVec,
  output logic                       done
);

  moveStrobe_t         strobe;
  logic [NUM_ELEM-1:0] posOk;
  logic [NUM_ELEM-1:0] idxOk;

  idxmv_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .scatterMode(scatterMode),
    .strobe     (strobe),
    .done       (done)
  );

  idxmv_bounds #(
    .NUM_ELEM(NUM_ELEM),
    .IDX_W   (IDX_W),
    .VL_W    (VL_W)
  ) u_bounds (
    .idxVec(idxVec),
    .vecLen(vecLen),
    .posOk (posOk),
    .idxOk (idxOk)
  );

  idxmv_datapath #(
    .NUM_ELEM(NUM_ELEM),
    .ELEM_W  (ELEM_W),
    .IDX_W   (IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcVec  (srcVec),
    .idxVec  (idxVec),
    .predMask(predMask),
    .oldVec  (oldVec),
    .posOk   (posOk),
    .idxOk   (idxOk),
    .dstVec  (dstVec)
  );

endmodule

// File: rtl/idxmv_checks.sv
module idxmv_checks #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16,
  parameter int IDX_W    = 4,
  parameter int VL_W     = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic                       scatterMode,
  input logic [VL_W-1:0]            vecLen,
  input logic [NUM_ELEM*ELEM_W-1:0] srcVec,
  input logic [NUM_ELEM*IDX_W-1:0]  idxVec,
  input logic [NUM_ELEM-1:0]        predMask,
  input logic [NUM_ELEM*ELEM_W-1:0] oldVec,
  input logic [NUM_ELEM*ELEM_W-1:0] dstVec,
  input logic                       done
);

  logic [VL_W-1:0] capLen;
  assign capLen = (vecLen > VL_W'(NUM_ELEM)) ? VL_W'(NUM_ELEM) : vecLen;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!done && dstVec == '0));

  p_done_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  p_done_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(dstVec));

  p_pred_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (start && predMask == '0) |=> (dstVec == $past(oldVec)));

  p_zero_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && vecLen == '0) |=> (dstVec == $past(oldVec)));

  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_tail
    p_tail_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
      (start && (capLen <= VL_W'(gi))) |=>
        (dstVec[gi*ELEM_W +: ELEM_W] == $past(oldVec[gi*ELEM_W +: ELEM_W])));
  end

endmodule

bind idxmv_unit idxmv_checks #(
  .NUM_ELEM(NUM_ELEM),
  .ELEM_W  (ELEM_W),
  .IDX_W   (IDX_W),
  .VL_W    (VL_W)
) u_checks (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .scatterMode(scatterMode),
  .vecLen     (vecLen),
  .srcVec     (srcVec),
  .idxVec     (idxVec),
  .predMask   (predMask),
  .oldVec     (oldVec),
  .dstVec     (dstVec),
  .done       (done)
);

// File: tb/idxmv_unit_test.sv
module idxmv_unit_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         scatterMode = 1'b0;
  logic [3:0]   vecLen = '0;
  logic [127:0] srcVec = '0;
  logic [31:0]  idxVec = '0;
  logic [7:0]   predMask = '0;
  logic [127:0] oldVec = '0;
  logic [127:0] dstVec;
  logic         done;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;

  localparam logic [127:0] SRC_A = 128'hA707_A606_A505_A404_A303_A202_A101_A000;
  localparam logic [127:0] OLD_A = 128'hC7C7_C6C6_C5C5_C4C4_C3C3_C2C2_C1C1_C0C0;

  always #4 clk = ~clk;

  idxmv_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .scatterMode(scatterMode),
    .vecLen(vecLen), .srcVec(srcVec), .idxVec(idxVec), .predMask(predMask),
    .oldVec(oldVec), .dstVec(dstVec), .done(done)
  );

  // Expected result from the requirements
  function automatic logic [127:0] refMove(input bit scat, input logic [127:0] src,
      input logic [31:0] idx, input logic [7:0] pred, input logic [127:0] old,
      input logic [3:0] vl);
    logic [127:0] res = old;
    int len = (vl > 4'd8) ? 8 : int'(vl);
    for (int i = 0; i < len; i++) begin
      int ix = int'(idx[4*i +: 4]);
      if (pred[i]) begin
        if (!scat) begin
          res[16*i +: 16] = (ix < len) ? src[16*ix +: 16] : 16'h0000;
        end else if (ix < len) begin
          res[16*ix +: 16] = src[16*i +: 16];
        end
      end
    end
    return res;
  endfunction

  task automatic checkVal(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runMove(input string tag, input bit scat, input logic [127:0] src,
      input logic [31:0] idx, input logic [7:0] pred, input logic [127:0] old,
      input logic [3:0] vl, input logic [127:0] exp);
    @(negedge clk);
    scatterMode = scat; srcVec = src; idxVec = idx; predMask = pred;
    oldVec = old; vecLen = vl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    srcVec = ~src; oldVec = ~old;
    checkVal({tag, " result"}, dstVec, exp);
    checkVal({"R2 done pulse high"}, {127'd0, done}, 128'd1);
    @(negedge clk);
    checkVal({"R2 done pulse low"}, {127'd0, done}, 128'd0);
    checkVal({"R2 result held"}, dstVec, exp);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkVal("R1 reset dstVec", dstVec, 128'd0);
    checkVal("R1 reset done", {127'd0, done}, 128'd0);
  endtask

  task automatic testGatherIdentity();
    runMove("R3 gather identity", 1'b0, SRC_A, 32'h7654_3210, 8'hFF, OLD_A, 4'd8, SRC_A);
  endtask

  task automatic testGatherReverse();
    logic [127:0] exp = 128'hA000_A101_A202_A303_A404_A505_A606_A707;
    runMove("R3 gather reverse", 1'b0, SRC_A, 32'h0123_4567, 8'hFF, OLD_A, 4'd8, exp);
  endtask

  task automatic testGatherOutOfRange();
    // length 5: idx 5,7,9,15 give zero; positions 5..7 keep old
    logic [32-1:0] idx = 32'h0123_F957;
    logic [127:0] exp = refMove(1'b0, SRC_A, idx, 8'hFF, OLD_A, 4'd5);
    runMove("R4 gather out-of-range zero", 1'b0, SRC_A, idx, 8'hFF, OLD_A, 4'd5, exp);
    checkVal("R6 tail kept", {80'd0, exp[127:80]}, {80'd0, OLD_A[127:80]});
  endtask

  task automatic testGatherPredicate();
    logic [127:0] exp = refMove(1'b0, SRC_A, 32'h0123_4567, 8'h5A, OLD_A, 4'd8);
    runMove("R5 gather predicate", 1'b0, SRC_A, 32'h0123_4567, 8'h5A, OLD_A, 4'd8, exp);
    runMove("R5 empty predicate", 1'b1, SRC_A, 32'h0123_4567, 8'h00, OLD_A, 4'd8, OLD_A);
  endtask

  task automatic testZeroLength();
    runMove("R6 zero length", 1'b0, SRC_A, 32'h7654_3210, 8'hFF, OLD_A, 4'd0, OLD_A);
  endtask

  task automatic testLengthAbove();
    // length 12 acts as 8; index 9 reads zero, index 3 reads element 3
    logic [127:0] exp = refMove(1'b0, SRC_A, 32'h9999_3333, 8'hFF, OLD_A, 4'd8);
    runMove("R7 length above capacity", 1'b0, SRC_A, 32'h9999_3333, 8'hFF, OLD_A, 4'd12, exp);
    // length 3: index 6 is in capacity but out of range
    exp = refMove(1'b0, SRC_A, 32'h0000_0601, 8'hFF, OLD_A, 4'd3);
    runMove("R7 length not capacity", 1'b0, SRC_A, 32'h0000_0601, 8'hFF, OLD_A, 4'd3, exp);
  endtask

  task automatic testScatterPermute();
    logic [127:0] exp = 128'hA000_A101_A202_A303_A404_A505_A606_A707;
    runMove("R8 scatter reverse", 1'b1, SRC_A, 32'h0123_4567, 8'hFF, OLD_A, 4'd8, exp);
  endtask

  task automatic testScatterDropped();
    // length 4: sources 0..3 target 6,1,0,9 -> only 1 and 0 written
    logic [127:0] exp = OLD_A;
    exp[16*1 +: 16] = 16'hA101;
    exp[16*0 +: 16] = 16'hA202;
    runMove("R9 scatter dropped writes", 1'b1, SRC_A, 32'h2222_9016, 8'hFF, OLD_A, 4'd4, exp);
  endtask

  task automatic testScatterCollision();
    logic [127:0] exp = OLD_A;
    exp[16*2 +: 16] = 16'hA707;
    runMove("R10 scatter collision", 1'b1, SRC_A, 32'h2222_2222, 8'hFF, OLD_A, 4'd8, exp);
    exp[16*2 +: 16] = 16'hA505;
    runMove("R10 collision with predicate", 1'b1, SRC_A, 32'h2222_2222, 8'h3F, OLD_A, 4'd8, exp);
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 20000) begin
      checkCount++;
      failCount++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=20000", cycleCount);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testGatherIdentity();
    testGatherReverse();
    testGatherOutOfRange();
    testGatherPredicate();
    testZeroLength();
    testLengthAbove();
    testScatterPermute();
    testScatterDropped();
    testScatterCollision();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule